// File: doc/BRIEF.md
# Peripheral Hard-Reset Supervisor

This block runs on the host side of a link to an attached peripheral controller. When the host's serial layer reports that an expected response did not arrive in time, the supervisor forces a hard restart of the peripheral. It does this by pulling the peripheral's active-low clear line low for a short, fixed pulse and then letting it go. After the release it holds off all traffic for a fixed start-up delay, counted in host clock cycles. It then watches an active-low ready line, which the peripheral pulls low once its own start-up code has finished.

The poll has a time limit. If the ready line is not seen within that window, the supervisor issues a fresh clear pulse. Once a set number of attempts have all gone unanswered, it gives up and raises a fault flag. A new response timeout clears the fault and starts the whole sequence again.

The sequence uses the states IDLE, PULSE, WAIT, POLL and READY. The transitions are as follows:
- IDLE or READY moves to PULSE on a timeout.
- PULSE moves to WAIT when the pulse count is reached.
- WAIT moves to POLL when the start-up delay has elapsed.
- POLL moves to READY when the ready line is seen.
- POLL moves back to PULSE when the poll window runs out and attempts remain.
- POLL moves to IDLE, with the fault flag set, when the poll window runs out on the last attempt.

Every cycle count is a parameter. The defaults correspond to a 50 MHz host with a 72 ms start-up delay (3,600,000 cycles).

Top module: `prst_supervisor`

## Requirements
- R1: After reset, clr_n is high, busy is low, periph_ok is high and fault is low.
- R2: When rsp_timeout is high at a clock edge while busy is low, clr_n goes low in the following cycle. While busy is low and rsp_timeout stays low, clr_n stays high whatever rdy_n does.
- R3: Each clear pulse keeps clr_n low for exactly PULSE_CYC consecutive cycles.
- R4: After clr_n is released, periph_ok stays low for at least WAIT_CYC cycles, whatever the state of rdy_n.
- R5: rdy_n (low = ready) passes through a two-flop synchronizer. Count cycle 0 as the first cycle in which clr_n is high again, and suppose rdy_n is driven low from cycle D onwards. Then periph_ok first reads high in cycle max(WAIT_CYC, D+2)+1. This holds provided max(WAIT_CYC, D+2) < WAIT_CYC+POLL_CYC.
- R6: busy is high and periph_ok is low from the first cycle of a clear pulse until ready is seen.
- R7: A rsp_timeout while busy is high is ignored. No extra pulse is issued and the ready timing of R5 is unchanged.
- R8: If ready is not seen in the POLL_CYC polling cycles, clr_n goes low again in cycle WAIT_CYC+POLL_CYC (counted as in R5), provided attempts remain.
- R9: Once MAX_TRIES pulses have gone unanswered, the block returns to idle in cycle WAIT_CYC+POLL_CYC of the last attempt. In that cycle fault is high, busy is low, periph_ok is low and clr_n is high.
- R10: A rsp_timeout while fault is high clears fault and starts a new clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_timeout | input | 1 | Response-timeout indication from the serial layer |
| clr_n | output | 1 | Active-low clear line driven to the peripheral |
| rdy_n | input | 1 | Active-low ready line from the peripheral (pulled up) |
| busy | output | 1 | A recovery sequence is in progress |
| periph_ok | output | 1 | Communication with the peripheral may proceed |
| fault | output | 1 | All recovery attempts failed |

## Verification
The recovery sequence is driven with random ready delays spread across the whole wait-plus-poll window, and the ready moment is predicted from each delay. This separates a ready line that is already low before the wait ends, where the wait bounds the timing, from one that arrives during the poll, where the synchronizer latency is visible.

Stray timeouts are injected during the wait and the poll. These show whether the state machine ignores triggers while busy.

Directed cases cover the following:
- the last poll cycle that still succeeds;
- the first ready delay that is one cycle too late, which forces a second pulse;
- a peripheral that never answers, which exhausts the attempts and raises the fault flag;
- a later timeout that clears the fault.

Quiet periods with a toggling ready line show that nothing starts without a timeout.

// File: rtl/prst_pkg.sv
package prst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PULSE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_POLL  = 3'd3,
        ST_READY = 3'd4
    } prst_state_e;

endpackage

// File: rtl/prst_sync.sv
// Two-flop synchronizer for one asynchronous level input.
module prst_sync #(
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;
    logic stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/prst_timer.sv
// Loadable down-counter: zero flags that the loaded interval has elapsed.
module prst_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign zero = (count == '0);
endmodule

// File: rtl/prst_tries.sv
// Attempt counter: restart sets it to one, each retry adds one.
module prst_tries #(
    parameter int MAX_TRIES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic bump,
    output logic last
);
    localparam int NW = $clog2(MAX_TRIES + 1);

    logic [NW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= NW'(1);
        end else if (bump && (cnt < NW'(MAX_TRIES))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt >= NW'(MAX_TRIES));
endmodule

// File: rtl/prst_supervisor.sv
module prst_supervisor
    import prst_pkg::*;
#(
    parameter int PULSE_CYC = 50,
    parameter int WAIT_CYC  = 3600000,
    parameter int POLL_CYC  = 1000000,
    parameter int MAX_TRIES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rsp_timeout,
    output logic clr_n,
    input  logic rdy_n,
    output logic busy,
    output logic periph_ok,
    output logic fault
);
    localparam int MAX_AB = (PULSE_CYC > WAIT_CYC) ? PULSE_CYC : WAIT_CYC;
    localparam int MAX_C  = (MAX_AB > POLL_CYC) ? MAX_AB : POLL_CYC;
    localparam int TW     = $clog2(MAX_C + 1);
    localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] WAIT_LD  = TW'(WAIT_CYC - 1);
    localparam logic [TW-1:0] POLL_LD  = TW'(POLL_CYC - 1);

    prst_state_e   st, st_nxt;
    logic          fault_q;
    logic          rdy_s;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_zero;
    logic          try_restart;
    logic          try_bump;
    logic          try_last;
    logic          flt_set;
    logic          flt_clr;

    prst_sync #(.RST_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(rdy_n),
        .q_sync (rdy_s)
    );

    prst_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .zero    (t_zero)
    );

    prst_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(try_restart),
        .bump   (try_bump),
        .last   (try_last)
    );

    // Next-state and control decode
    always_comb begin
        st_nxt      = st;
        t_load      = 1'b0;
        t_val       = '0;
        try_restart = 1'b0;
        try_bump    = 1'b0;
        flt_set     = 1'b0;
        flt_clr     = 1'b0;
        unique case (st)
            ST_IDLE, ST_READY: begin
                if (rsp_timeout) begin
                    st_nxt      = ST_PULSE;
                    t_load      = 1'b1;
                    t_val       = PULSE_LD;
                    try_restart = 1'b1;
                    flt_clr     = 1'b1;
                end
            end
            ST_PULSE: begin
                if (t_zero) begin
                    st_nxt = ST_WAIT;
                    t_load = 1'b1;
                    t_val  = WAIT_LD;
                end
            end
            ST_WAIT: begin
                if (t_zero) begin
                    st_nxt = ST_POLL;
                    t_load = 1'b1;
                    t_val  = POLL_LD;
                end
            end
            ST_POLL: begin
                if (!rdy_s) begin
                    st_nxt = ST_READY;
                end else if (t_zero) begin
                    if (try_last) begin
                        st_nxt  = ST_IDLE;
                        flt_set = 1'b1;
                    end else begin
                        st_nxt   = ST_PULSE;
                        t_load   = 1'b1;
                        t_val    = PULSE_LD;
                        try_bump = 1'b1;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Fault flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (flt_set) begin
            fault_q <= 1'b1;
        end else if (flt_clr) begin
            fault_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        clr_n     = 1'b1;
        busy      = 1'b0;
        periph_ok = 1'b0;
        unique case (st)
            ST_IDLE:  periph_ok = !fault_q;
            ST_PULSE: begin
                clr_n = 1'b0;
                busy  = 1'b1;
            end
            ST_WAIT:  busy = 1'b1;
            ST_POLL:  busy = 1'b1;
            ST_READY: periph_ok = 1'b1;
            default:  periph_ok = 1'b0;
        endcase
        fault = fault_q;
    end
endmodule

// File: rtl/prst_supervisor_chk.sv
module prst_supervisor_chk #(
    parameter int PULSE_CYC = 50,
    parameter int WAIT_CYC  = 3600000
) (
    input logic clk,
    input logic rst_n,
    input logic rsp_timeout,
    input logic clr_n,
    input logic busy,
    input logic periph_ok,
    input logic fault
);
    localparam int LW = $clog2(PULSE_CYC + 2);
    localparam int HW = $clog2(WAIT_CYC + 2);

    logic [LW-1:0] low_cnt;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            if (clr_n) begin
                low_cnt <= '0;
            end else if (low_cnt < LW'(PULSE_CYC + 1)) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (!clr_n) begin
                hi_cnt <= '0;
            end else if (hi_cnt < HW'(WAIT_CYC + 1)) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rsp_timeout) |=> clr_n);

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!clr_n && $past(rsp_timeout)));

    a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_n) |-> (low_cnt == LW'(PULSE_CYC)));

    a_r3_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= LW'(PULSE_CYC));

    a_r4_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_ok) |-> (hi_cnt > HW'(WAIT_CYC)));

    a_r6_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (busy && !periph_ok));

    a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && periph_ok));

    a_r9_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!periph_ok && !busy && clr_n));
endmodule

bind prst_supervisor prst_supervisor_chk #(
    .PULSE_CYC(PULSE_CYC),
    .WAIT_CYC (WAIT_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_timeout(rsp_timeout),
    .clr_n      (clr_n),
    .busy       (busy),
    .periph_ok  (periph_ok),
    .fault      (fault)
);

// File: tb/sim_prst_supervisor.sv
`timescale 1ns/1ps
module sim_prst_supervisor;
    localparam int P  = 5;
    localparam int W  = 40;
    localparam int Q  = 20;
    localparam int NT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rsp_timeout = 1'b0;
    logic rdy_n = 1'b1;
    logic clr_n, busy, periph_ok, fault;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    prst_supervisor #(
        .PULSE_CYC(P), .WAIT_CYC(W), .POLL_CYC(Q), .MAX_TRIES(NT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rsp_timeout(rsp_timeout), .clr_n(clr_n),
        .rdy_n(rdy_n), .busy(busy), .periph_ok(periph_ok), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected cycle index (from release) at which periph_ok reads high
    function automatic int ready_idx(input int d);
        int first_poll_hit;
        first_poll_hit = (W > d + 2) ? W : d + 2;
        return first_poll_hit + 1;
    endfunction

    // Issue a one-cycle timeout; on return we are at the negedge of the first
    // cycle after the trigger edge.
    task automatic trigger();
        rsp_timeout = 1'b1;
        @(negedge clk);
        rsp_timeout = 1'b0;
    endtask

    // Measure the clear pulse width at the ports; leaves at cycle 0 of release.
    task automatic measure_pulse(input string tag);
        int lowc;
        lowc = 0;
        while (!clr_n && lowc < 1000) begin
            rdy_n = 1'b1;
            if (!busy || periph_ok) chk(1'b0, "R6", int'(periph_ok), 0);
            lowc++;
            @(negedge clk);
        end
        chk(lowc == P, tag, lowc, P);
    endtask

    // Full successful recovery with ready delay d and optional injected timeout
    task automatic recover(input int d, input int inj);
        int i;
        int extra;
        chk(!clr_n, "R2", int'(clr_n), 0);
        measure_pulse("R3");
        i = 0;
        extra = 0;
        while (!periph_ok && i < 1000) begin
            if (!clr_n) extra++;
            if (!busy) chk(1'b0, "R6", int'(busy), 1);
            if (i == d) rdy_n = 1'b0;
            rsp_timeout = (i == inj);
            @(negedge clk);
            i++;
        end
        rsp_timeout = 1'b0;
        chk(extra == 0, "R7", extra, 0);
        chk(i >= W, "R4", i, W);
        chk(i == ready_idx(d), "R5", i, ready_idx(d));
        chk(!busy && !fault, "R6", int'(busy), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(clr_n && !busy && periph_ok && !fault, "R1", int'(periph_ok), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clr_n && !busy && periph_ok && !fault, "R1", int'(clr_n), 1);

        // R2: quiet idle with a wiggling ready line starts nothing
        for (int k = 0; k < 30; k++) begin
            rdy_n = 1'($urandom_range(0, 1));
            @(negedge clk);
            if (!clr_n || busy) chk(1'b0, "R2", int'(clr_n), 1);
        end
        chk(clr_n && !busy, "R2", int'(busy), 0);

        // Directed: ready already low (early), and last-cycle success
        trigger(); recover(0, -1);
        trigger(); recover(W + Q - 3, -1);
        // R7: stray timeouts in WAIT and in POLL
        trigger(); recover(W + 5, 10);
        trigger(); recover(W + 8, W + 2);

        // Random recoveries
        for (int k = 0; k < 8; k++) begin
            int d;
            int inj;
            d = $urandom_range(0, W + Q - 3);
            inj = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, W - 1)) : -1;
            @(negedge clk);
            trigger();
            recover(d, inj);
        end

        // R8: one cycle too late forces a second pulse, then success
        trigger();
        measure_pulse("R3");
        begin
            int i;
            i = 0;
            while (clr_n && i < 1000) begin
                if (i == W + Q - 2) rdy_n = 1'b0;
                @(negedge clk);
                i++;
            end
            chk(i == W + Q, "R8", i, W + Q);
        end
        recover(2, -1);

        // R9: peripheral never answers
        trigger();
        for (int t = 0; t < NT; t++) begin
            int i;
            measure_pulse("R3");
            i = 0;
            while (clr_n && busy && i < 1000) begin
                rdy_n = 1'b1;
                @(negedge clk);
                i++;
            end
            chk(i == W + Q, (t == NT - 1) ? "R9" : "R8", i, W + Q);
        end
        chk(fault && !busy && !periph_ok && clr_n, "R9", int'(fault), 1);
        repeat (10) @(negedge clk);
        chk(fault && clr_n, "R9", int'(fault), 1);

        // R10: new timeout clears the fault and recovers
        trigger();
        chk(!fault && !clr_n, "R10", int'(fault), 0);
        recover(7, -1);
        chk(!fault && periph_ok, "R10", int'(periph_ok), 1);

        finish_run();
    end
endmodule